// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. It has a single remainder register with feedback XOR taps. Four common generator polynomials are available, and the generator is chosen at run time, frame by frame. The register width in use is the degree of the chosen generator. A strobe opens each frame, and serial data bits follow, most significant bit first, each qualified by a valid signal. A marker on the valid cycle of the final data bit closes the data field. The data field may be any length, including a single bit.

In transmit mode the block divides the data, padded with as many zeros as the generator degree, by the generator. When the data ends, it shifts the remainder out serially, most significant bit first, so that the check sequence directly follows the data. In receive mode the whole frame is shifted in, check bits included. When the last bit arrives, the block raises the error flag if the frame is not an exact multiple of the generator. In both modes a done flag marks the end of the frame.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `done`, `err`, `fcs_valid` and `fcs_out` are all 0.
- R2: A cycle with `sof` high clears the remainder to zero and starts a new frame, even when a frame is already in progress. A `din_valid` in that same cycle is ignored.
- R3: The value on `poly_sel` chooses the generator: 0 gives x^12+x^11+x^3+x^2+x+1, 1 gives x^16+x^15+x^2+1, 2 gives x^16+x^12+x^5+1, and 3 gives the 32-bit generator 0x04C11DB7 (leading term implied). The register width equals the degree of the chosen generator. For example, the ASCII string "123456789" under select value 2 yields 0x31C3.
- R4: In transmit mode (`chk_mode`=0), `fcs_valid` is high for exactly W cycles, where W is the generator degree. These cycles start on the cycle after the clock edge that takes the bit marked `din_last`. On them, `fcs_out` carries the remainder of data·x^W divided by the generator, most significant bit first, with one bit per cycle.
- R5: After the final check bit has been shifted out, `done` goes high on the next cycle and stays high, with `err`=0 and `fcs_valid`=0, until the next `sof`.
- R6: In receive mode (`chk_mode`=1), on the cycle after the edge that takes the marked last bit, `done` goes high. `err` is 1 exactly when the received frame, taken as a polynomial, is not divisible by the generator. Both flags hold until the next `sof`.
- R7: Cycles with `din_valid` low leave the frame unchanged, so idle gaps between bits do not alter the result. A frame may carry a single data bit.
- R8: `poly_sel` and `chk_mode` are captured at `sof`. Changes to them later in the frame have no effect on the result.
- R9: `din_valid` pulses while the check sequence is being sent, or after `done`, are ignored. The outgoing check bits and the held flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_sel | input | 2 | Generator choice, captured at `sof` |
| chk_mode | input | 1 | 0 = transmit (append check), 1 = receive (verify), captured at `sof` |
| sof | input | 1 | Start-of-frame strobe, clears the remainder |
| din | input | 1 | Serial data bit, most significant first |
| din_valid | input | 1 | Qualifies `din` |
| din_last | input | 1 | Marks the final data bit (with `din_valid`) |
| fcs_out | output | 1 | Serial check-sequence bit, 0 when not sending |
| fcs_valid | output | 1 | High while check bits are on `fcs_out` |
| err | output | 1 | Nonzero remainder at end of a received frame |
| done | output | 1 | Frame finished; held until next `sof` |

## Verification
The hardest situation to reach is a restart or stray input that lands while state from an earlier frame is still live. Examples are a `sof` arriving mid-frame on a dirty remainder, `din_valid` pulses during check-sequence output, and a generator select that changes in the middle of a frame. The stimulus builds each of these deliberately. It aborts a partly sent frame with a new strobe, drives valid bits throughout the check-sequence phase and after done, and toggles the select and mode inputs during idle gaps between data bits. A long-division model in the bench computes the expected bit on every cycle, and every transmitted check sequence is fed back through receive mode both intact and with a single flipped bit.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned CNT_W = $clog2(REG_W);

  typedef enum logic [1:0] {
    GEN_C12   = 2'd0,
    GEN_C16   = 2'd1,
    GEN_CCITT = 2'd2,
    GEN_C32   = 2'd3
  } gen_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS,
    ST_DONE
  } frame_st_e;

  // Generator terms below the leading one.
  function automatic logic [REG_W-1:0] gen_taps(gen_sel_e s);
    case (s)
      GEN_C12:   return 32'h0000_080F;
      GEN_C16:   return 32'h0000_8005;
      GEN_CCITT: return 32'h0000_1021;
      default:   return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [5:0] gen_width(gen_sel_e s);
    case (s)
      GEN_C12:   return 6'd12;
      GEN_C16:   return 6'd16;
      GEN_CCITT: return 6'd16;
      default:   return 6'd32;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] width_mask(gen_sel_e s);
    case (s)
      GEN_C12:   return 32'h0000_0FFF;
      GEN_C16:   return 32'h0000_FFFF;
      GEN_CCITT: return 32'h0000_FFFF;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic msb_pick(logic [REG_W-1:0] r, gen_sel_e s);
    case (s)
      GEN_C12:   return r[11];
      GEN_C16:   return r[15];
      GEN_CCITT: return r[15];
      default:   return r[31];
    endcase
  endfunction

  // One division step: feed a bit in at the top of the register.
  function automatic logic [REG_W-1:0] lfsr_step(logic [REG_W-1:0] r, logic b, gen_sel_e s);
    logic [REG_W-1:0] nxt;
    nxt = (r << 1) & width_mask(s);
    if (msb_pick(r, s) ^ b) nxt = nxt ^ gen_taps(s);
    return nxt;
  endfunction

  // Plain shift used while the check sequence is sent out.
  function automatic logic [REG_W-1:0] drain_step(logic [REG_W-1:0] r, gen_sel_e s);
    return (r << 1) & width_mask(s);
  endfunction

endpackage

// File: rtl/crc_shift_core.sv
module crc_shift_core
  import crc_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_en,
  input  logic             step_bit,
  input  logic             drain_en,
  input  gen_sel_e         gen,
  output logic [REG_W-1:0] crc_q,
  output logic             next_zero
);

  logic [REG_W-1:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear)         crc_d = '0;
    else if (step_en)  crc_d = lfsr_step(crc_q, step_bit, gen);
    else if (drain_en) crc_d = drain_step(crc_q, gen);
  end

  assign next_zero = (crc_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  // R3: bits above the selected degree never become set
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q & ~width_mask(gen)) == '0);

  // R7: with no shift request the remainder holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step_en && !drain_en) |=> $stable(crc_q));

  // R2: a clear leaves an empty remainder
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0));

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             mode_in,
  input  gen_sel_e         gen_in,
  input  logic             din_valid,
  input  logic             din_last,
  input  logic             next_zero,
  output frame_st_e        st_q,
  output gen_sel_e         gen_q,
  output logic             mode_q,
  output logic             clear,
  output logic             step_en,
  output logic             drain_en,
  output logic             done_q,
  output logic             err_q
);

  logic [CNT_W-1:0] fcs_cnt_q;
  logic             frame_end;
  logic             drain_end;

  assign clear     = sof;
  assign step_en   = !sof && (st_q == ST_DATA) && din_valid;
  assign drain_en  = !sof && (st_q == ST_FCS);
  assign frame_end = step_en && din_last;
  assign drain_end = drain_en && (fcs_cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      gen_q     <= GEN_C12;
      mode_q    <= 1'b0;
      fcs_cnt_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else if (sof) begin
      st_q      <= ST_DATA;
      gen_q     <= gen_in;
      mode_q    <= mode_in;
      fcs_cnt_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_DATA: if (frame_end) begin
          if (mode_q) begin
            st_q   <= ST_DONE;
            done_q <= 1'b1;
            err_q  <= !next_zero;
          end else begin
            st_q      <= ST_FCS;
            fcs_cnt_q <= CNT_W'(gen_width(gen_q) - 6'd1);
          end
        end
        ST_FCS: begin
          if (drain_end) begin
            st_q   <= ST_DONE;
            done_q <= 1'b1;
          end else begin
            fcs_cnt_q <= fcs_cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: captured generator holds between strobes
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> ($stable(gen_q) && $stable(mode_q)));

  // R4: the drain counter stays inside the generator degree
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FCS) |-> ({1'b0, fcs_cnt_q} < gen_width(gen_q)));

  // R5: the final drain step leads straight to done
  p_drain_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_end |=> done_q);

  // R6: a transmit frame never reports an error
  p_tx_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mode_q) |-> !err_q);

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] poly_sel,
  input  logic       chk_mode,
  input  logic       sof,
  input  logic       din,
  input  logic       din_valid,
  input  logic       din_last,
  output logic       fcs_out,
  output logic       fcs_valid,
  output logic       err,
  output logic       done
);

  frame_st_e        st_q;
  gen_sel_e         gen_q;
  logic             mode_q;
  logic             clear;
  logic             step_en;
  logic             drain_en;
  logic             next_zero;
  logic [REG_W-1:0] crc_q;

  crc_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .mode_in   (chk_mode),
    .gen_in    (gen_sel_e'(poly_sel)),
    .din_valid (din_valid),
    .din_last  (din_last),
    .next_zero (next_zero),
    .st_q      (st_q),
    .gen_q     (gen_q),
    .mode_q    (mode_q),
    .clear     (clear),
    .step_en   (step_en),
    .drain_en  (drain_en),
    .done_q    (done),
    .err_q     (err)
  );

  crc_shift_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .step_en   (step_en),
    .step_bit  (din),
    .drain_en  (drain_en),
    .gen       (gen_q),
    .crc_q     (crc_q),
    .next_zero (next_zero)
  );

  assign fcs_valid = (st_q == ST_FCS);
  assign fcs_out   = fcs_valid & msb_pick(crc_q, gen_q);

  // R5: done and check output never overlap
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fcs_valid && !fcs_out));

  // R9: data pulses during output do not disturb the drain
  p_fcs_ignores_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_valid |-> !step_en);

  // R1: output line is quiet outside the check phase
  p_fcs_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fcs_valid |-> !fcs_out);

endmodule

// File: tb/test_crc_serial_unit.sv
module test_crc_serial_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] poly_sel = 2'd0;
  logic       chk_mode = 1'b0;
  logic       sof = 1'b0;
  logic       din = 1'b0;
  logic       din_valid = 1'b0;
  logic       din_last = 1'b0;
  logic       fcs_out, fcs_valid, err, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10ns clk = ~clk;

  crc_serial_unit i_crc_serial_unit (
    .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .chk_mode(chk_mode),
    .sof(sof), .din(din), .din_valid(din_valid), .din_last(din_last),
    .fcs_out(fcs_out), .fcs_valid(fcs_valid), .err(err), .done(done)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: generator with its leading term, and its degree.
  function automatic logic [63:0] ref_poly(int s);
    case (s)
      0: return 64'h180F;
      1: return 64'h18005;
      2: return 64'h11021;
      default: return 64'h1_04C1_1DB7;
    endcase
  endfunction

  function automatic int ref_deg(int s);
    return (s == 0) ? 12 : (s == 3) ? 32 : 16;
  endfunction

  // Long division of a bit queue, optionally padded with deg zeros.
  function automatic logic [63:0] ref_div(bit q[$], int s, bit pad);
    logic [63:0] r = 0;
    int w = ref_deg(s);
    int total = q.size() + (pad ? w : 0);
    for (int i = 0; i < total; i++) begin
      r = (r << 1) | ((i < q.size()) ? q[i] : 1'b0);
      if (r[w]) r = r ^ ref_poly(s);
    end
    return r;
  endfunction

  task automatic push_val(ref bit q[$], input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) q.push_back(v[i]);
  endtask

  task automatic start_frame(input int s, input bit m, input bit stray);
    sof = 1'b1; poly_sel = s[1:0]; chk_mode = m;
    din_valid = stray; din = 1'b1; din_last = stray;
    @(posedge clk); @(negedge clk);
    sof = 1'b0; din_valid = 1'b0; din_last = 1'b0;
  endtask

  // Send bits; gaps insert idle cycles with the select and mode wiggled.
  task automatic send_bits(bit q[$], input bit gaps);
    for (int i = 0; i < q.size(); i++) begin
      din = q[i]; din_valid = 1'b1; din_last = (i == q.size() - 1);
      @(posedge clk); @(negedge clk);
      din_valid = 1'b0; din_last = 1'b0;
      if (gaps && (i % 3 == 1)) begin
        poly_sel = 2'($urandom); chk_mode = ~chk_mode; din = ~din;
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  task automatic run_tx(input int s, bit q[$], input bit gaps, input bit stray,
                        output logic [63:0] got);
    int w = ref_deg(s);
    logic [63:0] exp = ref_div(q, s, 1'b1);
    got = 0;
    start_frame(s, 1'b0, 1'b0);
    send_bits(q, gaps);
    for (int i = w - 1; i >= 0; i--) begin
      if (stray) begin din_valid = 1'b1; din = 1'($urandom); din_last = 1'($urandom); end
      chk(fcs_valid, 1, "R4 fcs_valid during check phase");
      chk(fcs_out, exp[i], stray ? "R9 check bit under stray data" : "R4 check bit");
      chk(done, 0, "R5 done low while sending");
      got = (got << 1) | fcs_out;
      @(posedge clk); @(negedge clk);
    end
    din_valid = 1'b0; din_last = 1'b0;
    chk(done, 1, "R5 done after last check bit");
    chk(fcs_valid, 0, "R5 fcs_valid low after done");
    chk(err, 0, "R5 err low on transmit");
  endtask

  task automatic run_rx(input int s, bit q[$], input bit gaps);
    bit exp_err = (ref_div(q, s, 1'b0) != 0);
    start_frame(s, 1'b1, 1'b0);
    send_bits(q, gaps);
    chk(done, 1, "R6 done after received frame");
    chk(err, exp_err, "R6 err matches divisibility");
    chk(fcs_valid, 0, "R6 no check output in receive");
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit q[$];
    bit f[$];
    logic [63:0] got;
    repeat (3) @(negedge clk);
    chk({done, err, fcs_valid, fcs_out}, 0, "R1 outputs in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk({done, err, fcs_valid, fcs_out}, 0, "R1 outputs after reset");

    // R3: known check value for "123456789" under select 2
    q = {};
    for (int c = 49; c <= 57; c++) push_val(q, c, 8);
    run_tx(2, q, 1'b0, 1'b0, got);
    chk(got, 64'h31C3, "R3 CCITT known value");

    // R3 R4: each generator, receive loop-back good and corrupted
    for (int s = 0; s < 4; s++) begin
      q = {};
      push_val(q, 64'hA5C3_0F71 ^ s, 29 + s);
      run_tx(s, q, 1'b0, 1'b0, got);
      chk(got, ref_div(q, s, 1'b1), "R3 generator remainder");
      f = q; push_val(f, got, ref_deg(s));
      run_rx(s, f, 1'b0);
      f[5] = ~f[5];
      run_rx(s, f, 1'b0);
    end

    // R7: single-bit frame, remainder equals generator tail
    q = {1'b1};
    run_tx(0, q, 1'b0, 1'b0, got);
    chk(got, 64'h80F, "R7 single bit frame");

    // R2: abort a frame mid-way and restart on a dirty register
    q = {};
    push_val(q, 64'h1B7, 9);
    start_frame(1, 1'b0, 1'b0);
    send_bits({1'b1, 1'b1, 1'b0, 1'b1}, 1'b0);
    run_tx(1, q, 1'b0, 1'b0, got);
    chk(got, ref_div(q, 1, 1'b1), "R2 restart clears remainder");

    // R2: a valid bit alongside sof is dropped
    start_frame(3, 1'b0, 1'b1);
    send_bits(q, 1'b0);
    for (int i = 0; i < 32; i++) @(negedge clk);
    chk(done, 1, "R2 frame with stray bit at sof finished");

    // R7 R8: gaps with select and mode wiggling, stray data during output (R9)
    q = {};
    push_val(q, 64'h3C_9E51, 22);
    run_tx(3, q, 1'b1, 1'b1, got);
    f = q; push_val(f, got, 32);
    run_rx(2, f, 1'b1);
    chk(err, ref_div(f, 2, 1'b0) != 0, "R8 receive under wiggled select");

    // R9: pulses after done leave flags unchanged
    q = {};
    push_val(q, 64'h5A, 8);
    run_rx(1, q, 1'b0);
    send_bits({1'b1, 1'b0, 1'b1}, 1'b0);
    chk(done, 1, "R9 done held after stray data");
    chk(err, ref_div(q, 1, 1'b0) != 0, "R9 err held after stray data");
    chk(fcs_valid, 0, "R9 no output after stray data");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule